// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns bytes held in a small transmit queue into asynchronous serial frames on a single output line. Each frame is a low start bit, then 6, 7 or 8 data bits sent least significant bit first, then an optional parity bit, then a stop period of one, one and a half or two bit times. The line rests high between frames. The character length, the parity mode and the stop length come from encoded mode fields. The block samples them when a frame starts, so a frame already in flight is not changed by a later edit of a field.

Bit timing comes from an external rate generator. That generator pulses `bitTick` OVS times per bit period. Command pulses switch the transmitter on and off and force a break, which holds the line low. A flow-control enable makes each new frame wait until the clear-to-send input is high. Three status flags tell the surrounding logic whether the block has drained, whether the queue is full, and whether a frame is on the line.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, `txd` is 1, `fifoEmpty` is 1, `fifoFull` is 0 and `txActive` is 0. The transmitter starts disabled, so queued bytes wait until an enable command arrives.
- R2: A frame starts with one low bit. The data bits follow LSB first. `charLen` selects the data length: 2'b00 or 2'b01 give 8 bits, 2'b10 gives 7 bits, 2'b11 gives 6 bits. For shorter lengths the upper bits of the byte are not sent.
- R3: `parityMode` selects the parity bit, which follows the data. 3'b000 makes the total count of ones even and 3'b001 makes it odd. 3'b010 always sends 0 and 3'b011 always sends 1. Any value with bit 2 set sends no parity bit.
- R4: `stopMode` sets the stop period: 2'b00 is OVS ticks, 2'b01 is OVS + OVS/2 ticks, 2'b10 is 2*OVS ticks, and the reserved 2'b11 acts as 2'b00. `txActive` stays high for exactly OVS*(1 + data bits + parity bits) + stop ticks.
- R5: A `txEnableCmd` pulse enables the transmitter and a `txDisableCmd` pulse disables it. If both arrive in the same cycle, disable wins. A frame already in progress always completes, but no further frame starts while the transmitter is disabled.
- R6: When `flowCtrlEn` is 1, a frame may start only while `cts` is 1. If `cts` drops during a frame, that frame still completes.
- R7: A `breakStartCmd` pulse forces `txd` to 0 from the next cycle on, until a `breakStopCmd` pulse releases it. If both arrive together, the stop command wins. No frame starts while the break is held.
- R8: The queue holds DEPTH bytes and sends them in write order. `fifoFull` is 1 when DEPTH bytes are waiting. A write made while the queue is full is dropped.
- R9: `fifoEmpty` is 1 only when the queue is empty and the last stop period has ended. `txActive` is 1 from the start bit to the end of the stop period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | Oversample tick, OVS ticks per bit |
| wrStrobe | input | 1 | Write `wrData` into the queue |
| wrData | input | 8 | Byte to transmit |
| charLen | input | 2 | Data length select |
| parityMode | input | 3 | Parity select |
| stopMode | input | 2 | Stop length select |
| txEnableCmd | input | 1 | Enable pulse |
| txDisableCmd | input | 1 | Disable pulse |
| breakStartCmd | input | 1 | Start break pulse |
| breakStopCmd | input | 1 | Stop break pulse |
| flowCtrlEn | input | 1 | Gate frame starts on `cts` |
| cts | input | 1 | Clear to send, active high |
| txd | output | 1 | Serial output line |
| fifoEmpty | output | 1 | Queue empty and line idle |
| fifoFull | output | 1 | Queue full |
| txActive | output | 1 | Frame on the line |

## Verification
Enable and disable pulses can land in the same cycle. The bench does this while a frame is running and a second byte is waiting. It then checks that the running frame completes on the line and that the waiting byte stays queued, with `txActive` low and `fifoEmpty` low, until a lone enable pulse arrives. A queued write can also meet a held break or a low `cts`. In those cases the bench checks that no frame starts until the gate opens, and then that the frame comes out intact.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

  localparam int CHAR_MAX = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP
  } phase_e;

  // Control-to-datapath strobes and levels
  typedef struct packed {
    logic   load;     // pop head byte into shifter
    logic   shift;    // advance to next data bit
    phase_e phase;    // current frame section
    logic   holdLow;  // break in force
  } txf_ctrl_s;

  function automatic logic [3:0] dataBits(input logic [1:0] lenSel);
    case (lenSel)
      2'b10:   return 4'd7;
      2'b11:   return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/txf_control.sv
module txf_control
  import uart_txf_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic [1:0] charLen,
  input  logic [2:0] parityMode,
  input  logic [1:0] stopMode,
  input  logic       txEnableCmd,
  input  logic       txDisableCmd,
  input  logic       breakStartCmd,
  input  logic       breakStopCmd,
  input  logic       flowCtrlEn,
  input  logic       cts,
  input  logic       fifoHasData,
  output txf_ctrl_s  ctrl,
  output logic       txActive
);

  localparam int CW = $clog2(2 * OVS);
  localparam logic [CW-1:0] BIT_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(OVS + OVS / 2 - 1);
  localparam logic [CW-1:0] TWO_LAST = CW'(2 * OVS - 1);

  phase_e        phase;
  logic [CW-1:0] tickCnt;
  logic [CW-1:0] stopLast;
  logic [CW-1:0] stopLastFor;
  logic [3:0]    bitsLeft;
  logic          parOn;
  logic          txEnabled;
  logic          breakOn;
  logic          startOk;
  logic          phaseEnd;

  always_comb begin
    case (stopMode)
      2'b01:   stopLastFor = HALF_LAST;
      2'b10:   stopLastFor = TWO_LAST;
      default: stopLastFor = BIT_LAST;
    endcase
  end

  assign startOk  = (phase == PH_IDLE) && txEnabled && fifoHasData &&
                    (!flowCtrlEn || cts) && !breakOn;
  assign phaseEnd = bitTick &&
                    ((phase == PH_STOP) ? (tickCnt == stopLast) : (tickCnt == BIT_LAST));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      tickCnt   <= '0;
      stopLast  <= BIT_LAST;
      bitsLeft  <= '0;
      parOn     <= 1'b0;
      txEnabled <= 1'b0;
      breakOn   <= 1'b0;
    end else begin
      if (txDisableCmd)     txEnabled <= 1'b0;
      else if (txEnableCmd) txEnabled <= 1'b1;

      if (breakStopCmd)       breakOn <= 1'b0;
      else if (breakStartCmd) breakOn <= 1'b1;

      case (phase)
        PH_IDLE: begin
          if (startOk) begin
            phase    <= PH_START;
            tickCnt  <= '0;
            bitsLeft <= dataBits(charLen);
            parOn    <= !parityMode[2];
            stopLast <= stopLastFor;
          end
        end
        default: begin
          if (phaseEnd) begin
            tickCnt <= '0;
            case (phase)
              PH_START:  phase <= PH_DATA;
              PH_DATA: begin
                bitsLeft <= bitsLeft - 4'd1;
                if (bitsLeft == 4'd1) phase <= parOn ? PH_PARITY : PH_STOP;
              end
              PH_PARITY: phase <= PH_STOP;
              default:   phase <= PH_IDLE;
            endcase
          end else if (bitTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign ctrl.load    = startOk;
  assign ctrl.shift   = (phase == PH_DATA) && phaseEnd;
  assign ctrl.phase   = phase;
  assign ctrl.holdLow = breakOn;
  assign txActive     = (phase != PH_IDLE);

endmodule

// File: rtl/txf_datapath.sv
module txf_datapath
  import uart_txf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrStrobe,
  input  logic [CHAR_MAX-1:0] wrData,
  input  logic [1:0]          charLen,
  input  logic [2:0]          parityMode,
  input  txf_ctrl_s           ctrl,
  output logic                txd,
  output logic                fifoHasData,
  output logic                fifoFull
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [CHAR_MAX-1:0] mem [DEPTH];
  logic [AW-1:0]       wrPtr;
  logic [AW-1:0]       rdPtr;
  logic [AW:0]         count;
  logic                push;
  logic                pop;
  logic [CHAR_MAX-1:0] head;
  logic [CHAR_MAX-1:0] lenMask;
  logic                onesOdd;
  logic                parNext;
  logic [CHAR_MAX-1:0] shreg;
  logic                parBit;

  assign fifoFull    = (count == (AW + 1)'(DEPTH));
  assign fifoHasData = (count != '0);
  assign push        = wrStrobe && !fifoFull;
  assign pop         = ctrl.load && fifoHasData;
  assign head        = mem[rdPtr];

  always_comb begin
    for (int i = 0; i < CHAR_MAX; i++) begin
      lenMask[i] = (i < int'(dataBits(charLen)));
    end
  end

  assign onesOdd = ^(head & lenMask);

  always_comb begin
    case (parityMode[1:0])
      2'b00:   parNext = onesOdd;
      2'b01:   parNext = !onesOdd;
      2'b10:   parNext = 1'b0;
      default: parNext = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      shreg  <= '0;
      parBit <= 1'b0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (pop) begin
        shreg  <= head;
        parBit <= parNext;
      end else if (ctrl.shift) begin
        shreg  <= shreg >> 1;
      end
    end
  end

  always_comb begin
    if (ctrl.holdLow) txd = 1'b0;
    else begin
      case (ctrl.phase)
        PH_START:  txd = 1'b0;
        PH_DATA:   txd = shreg[0];
        PH_PARITY: txd = parBit;
        default:   txd = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_txf_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       wrStrobe,
  input  logic [7:0] wrData,
  input  logic [1:0] charLen,
  input  logic [2:0] parityMode,
  input  logic [1:0] stopMode,
  input  logic       txEnableCmd,
  input  logic       txDisableCmd,
  input  logic       breakStartCmd,
  input  logic       breakStopCmd,
  input  logic       flowCtrlEn,
  input  logic       cts,
  output logic       txd,
  output logic       fifoEmpty,
  output logic       fifoFull,
  output logic       txActive
);

  txf_ctrl_s ctrlBus;
  logic      fifoHasData;
  logic      breakHeld;

  txf_control #(.OVS(OVS)) control_i (
    .clk          (clk),
    .rstN         (rstN),
    .bitTick      (bitTick),
    .charLen      (charLen),
    .parityMode   (parityMode),
    .stopMode     (stopMode),
    .txEnableCmd  (txEnableCmd),
    .txDisableCmd (txDisableCmd),
    .breakStartCmd(breakStartCmd),
    .breakStopCmd (breakStopCmd),
    .flowCtrlEn   (flowCtrlEn),
    .cts          (cts),
    .fifoHasData  (fifoHasData),
    .ctrl         (ctrlBus),
    .txActive     (txActive)
  );

  txf_datapath #(.DEPTH(DEPTH)) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrStrobe   (wrStrobe),
    .wrData     (wrData),
    .charLen    (charLen),
    .parityMode (parityMode),
    .ctrl       (ctrlBus),
    .txd        (txd),
    .fifoHasData(fifoHasData),
    .fifoFull   (fifoFull)
  );

  assign fifoEmpty = !fifoHasData && !txActive;
  assign breakHeld = ctrlBus.holdLow;

endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
  input logic clk,
  input logic rstN,
  input logic txd,
  input logic fifoEmpty,
  input logic fifoFull,
  input logic txActive,
  input logic txDisableCmd,
  input logic breakStartCmd,
  input logic breakStopCmd,
  input logic flowCtrlEn,
  input logic cts,
  input logic breakOn
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!txActive && !breakOn) |-> txd);

  assert_disable_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(txDisableCmd) && !txActive) |=> !txActive);

  assert_cts_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flowCtrlEn && !cts && !txActive) |=> !txActive);

  assert_break_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (breakStartCmd && !breakStopCmd) |=> !txd);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));

  assert_empty_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |-> !txActive);

endmodule

bind uart_tx_framer uart_tx_framer_chk chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .txd          (txd),
  .fifoEmpty    (fifoEmpty),
  .fifoFull     (fifoFull),
  .txActive     (txActive),
  .txDisableCmd (txDisableCmd),
  .breakStartCmd(breakStartCmd),
  .breakStopCmd (breakStopCmd),
  .flowCtrlEn   (flowCtrlEn),
  .cts          (cts),
  .breakOn      (breakHeld)
);

// File: tb/uart_tx_framer_tb_top.sv
module uart_tx_framer_tb_top;

  localparam int OVS   = 8;
  localparam int DEPTH = 4;

  typedef struct {
    logic [7:0] d;
    logic [1:0] len;
    logic [2:0] par;
    logic [1:0] stop;
  } exp_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b1;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] charLen = 2'b00;
  logic [2:0] parityMode = 3'b100;
  logic [1:0] stopMode = 2'b00;
  logic       txEnableCmd = 1'b0;
  logic       txDisableCmd = 1'b0;
  logic       breakStartCmd = 1'b0;
  logic       breakStopCmd = 1'b0;
  logic       flowCtrlEn = 1'b0;
  logic       cts = 1'b1;
  logic       txd, fifoEmpty, fifoFull, txActive;

  int   total = 0;
  int   bad = 0;
  bit   finished = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  uart_tx_framer #(.OVS(OVS), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .wrStrobe(wrStrobe), .wrData(wrData),
    .charLen(charLen), .parityMode(parityMode), .stopMode(stopMode),
    .txEnableCmd(txEnableCmd), .txDisableCmd(txDisableCmd),
    .breakStartCmd(breakStartCmd), .breakStopCmd(breakStopCmd),
    .flowCtrlEn(flowCtrlEn), .cts(cts),
    .txd(txd), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .txActive(txActive)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int lenOf(logic [1:0] l);
    return (l == 2'b10) ? 7 : (l == 2'b11) ? 6 : 8;
  endfunction

  function automatic int stopTicks(logic [1:0] s);
    return (s == 2'b01) ? OVS + OVS / 2 : (s == 2'b10) ? 2 * OVS : OVS;
  endfunction

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic expectByte(logic [7:0] d);
    exp_t e;
    e.d = d; e.len = charLen; e.par = parityMode; e.stop = stopMode;
    q.push_back(e);
  endtask

  task automatic pushByte(logic [7:0] d, bit sent);
    @(negedge clk);
    wrStrobe = 1'b1; wrData = d;
    @(negedge clk);
    wrStrobe = 1'b0;
    if (sent) expectByte(d);
  endtask

  task automatic pulse(bit en, bit dis, bit bs, bit bp);
    @(negedge clk);
    txEnableCmd = en; txDisableCmd = dis; breakStartCmd = bs; breakStopCmd = bp;
    @(negedge clk);
    txEnableCmd = 0; txDisableCmd = 0; breakStartCmd = 0; breakStopCmd = 0;
  endtask

  task automatic drain();
    do @(negedge clk); while (!(fifoEmpty && q.size() == 0 && !txActive));
    repeat (3) @(negedge clk);
  endtask

  // Monitor: decode each frame while txActive is high and compare to scoreboard
  initial begin
    bit         prevAct;
    bit         have;
    int         cnt;
    int         nb;
    int         n;
    int         p;
    int         idx;
    logic [11:0] raw;
    logic [11:0] expRaw;
    exp_t       cur;
    prevAct = 0; have = 0; cnt = 0; nb = 0; n = 0; p = 0; raw = '0;
    forever begin
      @(negedge clk);
      if (txActive) begin
        if (!prevAct) begin
          cnt = 0; raw = '0;
          have = (q.size() > 0);
          if (have) begin
            cur = q.pop_front();
            n = lenOf(cur.len);
            p = cur.par[2] ? 0 : 1;
            nb = 2 + n + p;
          end else begin
            check("R8", "unexpected frame", 1, 0);
          end
        end else begin
          cnt++;
        end
        if (have && cnt >= OVS / 2 && ((cnt - OVS / 2) % OVS) == 0) begin
          idx = (cnt - OVS / 2) / OVS;
          if (idx < nb) raw[idx] = txd;
        end
      end else if (prevAct && have) begin
        int ones;
        expRaw = '0;
        ones = 0;
        for (int i = 0; i < n; i++) begin
          expRaw[1 + i] = cur.d[i];
          ones += cur.d[i];
        end
        if (p == 1) begin
          case (cur.par[1:0])
            2'b00: expRaw[1 + n] = (ones % 2 == 1);
            2'b01: expRaw[1 + n] = (ones % 2 == 0);
            2'b10: expRaw[1 + n] = 1'b0;
            default: expRaw[1 + n] = 1'b1;
          endcase
        end
        expRaw[1 + n + p] = 1'b1;
        // R2 framing and data bits, R3 parity bit
        check(p ? "R3" : "R2", "frame bits", int'(raw), int'(expRaw));
        // R4 frame length including stop period
        check("R4", "active cycles", cnt + 1, OVS * (1 + n + p) + stopTicks(cur.stop));
        have = 0;
      end
      prevAct = txActive;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check("R9", "watchdog expired", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "txd idle", txd, 1);
    check("R1", "fifoEmpty", fifoEmpty, 1);
    check("R1", "fifoFull", fifoFull, 0);
    check("R1", "txActive", txActive, 0);

    // R1 disabled after reset
    pushByte(8'hA5, 1);
    repeat (30) @(negedge clk);
    check("R1", "no start while disabled", txActive, 0);
    check("R9", "queue not drained", fifoEmpty, 0);
    pulse(1, 0, 0, 0);
    @(negedge clk);
    check("R9", "empty low during frame", fifoEmpty, 0);
    drain();
    check("R9", "empty after frame", fifoEmpty, 1);

    // R2 8-bit frames
    pushByte(8'h3C, 1);
    pushByte(8'h01, 1);
    drain();

    // R2/R3/R4 mode combinations
    charLen = 2'b10; parityMode = 3'b000; stopMode = 2'b00;
    pushByte(8'hD3, 1); drain();
    charLen = 2'b11; parityMode = 3'b001; stopMode = 2'b10;
    pushByte(8'h2C, 1); drain();
    charLen = 2'b00; parityMode = 3'b010; stopMode = 2'b01;
    pushByte(8'hE1, 1); drain();
    charLen = 2'b01; parityMode = 3'b011; stopMode = 2'b11;
    pushByte(8'h0F, 1); drain();
    charLen = 2'b00; parityMode = 3'b101; stopMode = 2'b00;
    pushByte(8'h80, 1); drain();
    charLen = 2'b11; parityMode = 3'b000; stopMode = 2'b01;
    pushByte(8'h07, 1); drain();
    charLen = 2'b00; parityMode = 3'b100; stopMode = 2'b00;

    // R8 full queue, dropped write, order
    pulse(0, 1, 0, 0);
    pushByte(8'h11, 1);
    pushByte(8'h22, 1);
    pushByte(8'h33, 1);
    check("R8", "not full at DEPTH-1", fifoFull, 0);
    pushByte(8'h44, 1);
    check("R8", "full at DEPTH", fifoFull, 1);
    pushByte(8'h55, 0);
    check("R8", "still full after drop", fifoFull, 1);
    pulse(1, 0, 0, 0);
    drain();
    check("R8", "no leftover frames", q.size(), 0);

    // R5 enable and disable in the same cycle during a frame
    pushByte(8'h96, 1);
    pushByte(8'h69, 0);
    do @(negedge clk); while (!txActive);
    pulse(1, 1, 0, 0);
    do @(negedge clk); while (txActive);
    repeat (3 * 10 * OVS) @(negedge clk);
    check("R5", "second frame held", txActive, 0);
    check("R5", "byte kept queued", fifoEmpty, 0);
    check("R5", "first frame done", q.size(), 0);
    expectByte(8'h69);
    pulse(1, 0, 0, 0);
    drain();

    // R6 clear-to-send gating
    flowCtrlEn = 1'b1; cts = 1'b0;
    pushByte(8'hC3, 1);
    repeat (40) @(negedge clk);
    check("R6", "no start without cts", txActive, 0);
    cts = 1'b1;
    do @(negedge clk); while (!txActive);
    cts = 1'b0;
    drain();
    pushByte(8'h12, 1);
    repeat (40) @(negedge clk);
    check("R6", "second byte gated", txActive, 0);
    flowCtrlEn = 1'b0;
    drain();
    cts = 1'b1;

    // R7 break
    pulse(0, 0, 1, 0);
    check("R7", "line low in break", txd, 0);
    pushByte(8'h5A, 1);
    repeat (40) @(negedge clk);
    check("R7", "no start in break", txActive, 0);
    check("R7", "line still low", txd, 0);
    pulse(0, 0, 1, 1);
    check("R7", "stop wins over start", txd, 1);
    drain();

    check("R8", "scoreboard empty at end", q.size(), 0);
    finishRun();
  end

endmodule